// File: doc/BRIEF.md
# Byte-Packing Host Data Buffer

This block is a small shift buffer between a 16-bit host data port and a byte-wide bus engine. One storage array of `DEPTH` bytes is shared by both directions. At any moment it holds transmit bytes or receive bytes, never both. On the transmit side the host loads one or two bytes per write and the engine takes them one at a time, oldest first. On the receive side the engine appends single bytes and the host drains them two per read. A byte-order control selects which half of the 16-bit host word travels first.

A four-state-free controller with three states tracks what the storage holds:

- `ST_IDLE`: empty.
- `ST_TXHOLD`: transmit bytes held.
- `ST_RXHOLD`: receive bytes held.

The transitions are:

- T1 `ST_IDLE`→`ST_TXHOLD`: an accepted host write.
- T2 `ST_TXHOLD`→`ST_IDLE`: a pop that takes the last transmit byte.
- T3 `ST_IDLE`→`ST_RXHOLD`: an accepted push.
- T4 `ST_RXHOLD`→`ST_IDLE`: a read that leaves no receive byte.
- T5 any state→`ST_IDLE`: a start of transfer.

Status outputs report both byte counts and the following flags:

- ready flags for each direction;
- a sticky flag for a lone-byte read;
- transmit-underflow and receive-overrun flags;
- a one-cycle access-error pulse.

Top module: `bytepack_buf`

## Requirements
- R1: While reset is asserted, and after it, both counts, `rd_data_o`, `tx_byte_o` and every flag are zero.
- R2: One request is acted on per clock, in the priority start, write, read, pop, push. A lower-priority request raised in the same cycle has no effect.
- R3: A 16-bit write (`wr_byte_i`=0) is accepted only when no receive byte is held and the transmit count is at most `DEPTH`-2. An accepted write raises the transmit count by 2. A refused write leaves the count and the held bytes unchanged.
- R4: A byte write (`wr_byte_i`=1) takes `wr_data_i[7:0]`. It follows the same acceptance rule as R3 and raises the transmit count by 1.
- R5: For a 16-bit write with `swap_i`=0, `wr_data_i[7:0]` is sent before `wr_data_i[15:8]`. With `swap_i`=1, `wr_data_i[15:8]` is sent first.
- R6: `tx_byte_o` shows the oldest held transmit byte, or zero when none is held, and a pop removes that byte. A pop with no transmit byte sets `tx_udf_o`. Any write, accepted or refused, clears `tx_udf_o`.
- R7: `tx_rdy_o` clears when an accepted write leaves more than `DEPTH`-2 bytes. It sets on a pop that leaves at most `DEPTH`-2 bytes, and on start.
- R8: A push is accepted only when no transmit byte is held and fewer than `DEPTH` receive bytes are held. Otherwise the byte is dropped and `rx_ovr_o` is set. Any read clears `rx_ovr_o`. `rx_rdy_o` is high exactly when the receive count is nonzero.
- R9: A read with two or more bytes held returns the two oldest bytes in `rd_data_o`, updated at the clock edge of the read. With `swap_i`=0 the oldest byte is in bits [7:0]; with `swap_i`=1 it is in bits [15:8]. The receive count drops by 2.
- R10: A read with exactly one byte held returns that byte, with the other byte of `rd_data_o` zero. It empties the buffer and sets `single_o`, which only start clears.
- R11: A read with no receive byte held returns zero, leaves both counts unchanged, and raises `acc_err_o` for that one cycle.
- R12: Start empties the storage and both counts, clears `rx_rdy_o` and `single_o`, sets `tx_rdy_o`, and leaves `tx_udf_o` and `rx_ovr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of transfer: empty the buffer |
| swap_i | input | 1 | Byte-order select for host writes and reads |
| wr_en_i | input | 1 | Host data write request |
| wr_byte_i | input | 1 | 1: byte write, 0: 16-bit write |
| wr_data_i | input | 16 | Host write data |
| rd_en_i | input | 1 | Host data read request |
| rd_data_o | output | 16 | Data returned by the last read |
| tx_pop_i | input | 1 | Engine takes the oldest transmit byte |
| tx_byte_o | output | 8 | Oldest transmit byte |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_cnt_o | output | 3 | Transmit bytes held |
| rx_cnt_o | output | 3 | Receive bytes held |
| tx_rdy_o | output | 1 | Transmit side has room for a 16-bit write |
| rx_rdy_o | output | 1 | Receive bytes available |
| single_o | output | 1 | A read returned a lone byte |
| tx_udf_o | output | 1 | Pop with nothing held |
| rx_ovr_o | output | 1 | Received byte dropped |
| acc_err_o | output | 1 | Read of an empty receive buffer (one cycle) |

## Verification
The properties assume that every request input is synchronous to `clk` and free of X once reset is released. They also assume that a request's effect depends on the higher-priority requests in the same cycle, so each property qualifies its antecedent with the absence of start and, where relevant, of a write. The stimulus is driven on the falling edge from tasks. It first walks the directed corner cases, then issues independent random requests with overlaps, so that the priority order and every refusal path are exercised against a queue-based reference model.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;

    // What the shared storage currently holds
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TXHOLD = 2'd1,
        ST_RXHOLD = 2'd2
    } bp_state_e;

    // The single request acted on in a cycle
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_POP   = 3'd4,
        OP_PUSH  = 3'd5
    } bp_op_e;

endpackage

// File: rtl/bytepack_arb.sv
module bytepack_arb
    import bytepack_pkg::*;
(
    input  logic   start_i,
    input  logic   wr_i,
    input  logic   rd_i,
    input  logic   pop_i,
    input  logic   push_i,
    output bp_op_e op_o
);

    // Fixed priority: start, write, read, pop, push (R2)
    always_comb begin
        if (start_i)     op_o = OP_START;
        else if (wr_i)   op_o = OP_WRITE;
        else if (rd_i)   op_o = OP_READ;
        else if (pop_i)  op_o = OP_POP;
        else if (push_i) op_o = OP_PUSH;
        else             op_o = OP_NONE;
    end

endmodule

// File: rtl/bytepack_swap.sv
module bytepack_swap #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  swap_en_i,
    input  logic [2*BYTE_W-1:0]   din_i,
    output logic [2*BYTE_W-1:0]   dout_o
);

    always_comb begin
        if (swap_en_i) dout_o = {din_i[BYTE_W-1:0], din_i[2*BYTE_W-1:BYTE_W]};
        else           dout_o = din_i;
    end

endmodule

// File: rtl/bytepack_txsel.sv
module bytepack_txsel #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic [DEPTH*BYTE_W-1:0]      data_i,
    input  logic [$clog2(DEPTH+1)-1:0]   cnt_i,
    output logic [BYTE_W-1:0]            byte_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    // Oldest transmit byte sits in slot cnt-1
    always_comb begin
        byte_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_i == CNT_W'(i + 1)) byte_o = data_i[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/bytepack_buf.sv
module bytepack_buf
    import bytepack_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          swap_i,
    input  logic                          wr_en_i,
    input  logic                          wr_byte_i,
    input  logic [2*BYTE_W-1:0]           wr_data_i,
    input  logic                          rd_en_i,
    output logic [2*BYTE_W-1:0]           rd_data_o,
    input  logic                          tx_pop_i,
    output logic [BYTE_W-1:0]             tx_byte_o,
    input  logic                          rx_push_i,
    input  logic [BYTE_W-1:0]             rx_byte_i,
    output logic [$clog2(DEPTH+1)-1:0]    tx_cnt_o,
    output logic [$clog2(DEPTH+1)-1:0]    rx_cnt_o,
    output logic                          tx_rdy_o,
    output logic                          rx_rdy_o,
    output logic                          single_o,
    output logic                          tx_udf_o,
    output logic                          rx_ovr_o,
    output logic                          acc_err_o
);

    localparam int unsigned HOST_W = 2 * BYTE_W;
    localparam int unsigned BUF_W  = DEPTH * BYTE_W;
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WR_LIMIT = CNT_W'(DEPTH - 2);

    bp_state_e         state_q, state_d;
    bp_op_e            op;
    logic [BUF_W-1:0]  data_q;
    logic [CNT_W-1:0]  txc_q, rxc_q, tx_add, tx_next;
    logic [HOST_W-1:0] wr_word, rd_raw, rd_word, rd_q;
    logic              wr_ok, push_ok, rd_drains;
    logic              tx_rdy_q, rx_rdy_q, single_q, udf_q, ovr_q, err_q;

    bytepack_arb u_arb (
        .start_i (start_i),
        .wr_i    (wr_en_i),
        .rd_i    (rd_en_i),
        .pop_i   (tx_pop_i),
        .push_i  (rx_push_i),
        .op_o    (op)
    );

    // Write path: the byte sent first goes to the upper half
    bytepack_swap #(.BYTE_W(BYTE_W)) u_wr_swap (
        .swap_en_i (~swap_i),
        .din_i     (wr_data_i),
        .dout_o    (wr_word)
    );

    // Read path: oldest byte lands low unless swapped
    bytepack_swap #(.BYTE_W(BYTE_W)) u_rd_swap (
        .swap_en_i (swap_i),
        .din_i     (rd_raw),
        .dout_o    (rd_word)
    );

    bytepack_txsel #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_txsel (
        .data_i (data_q),
        .cnt_i  (txc_q),
        .byte_o (tx_byte_o)
    );

    always_comb begin
        wr_ok     = (state_q != ST_RXHOLD) && (txc_q <= WR_LIMIT);
        push_ok   = (state_q != ST_TXHOLD) && (rxc_q != CNT_FULL);
        tx_add    = wr_byte_i ? CNT_ONE : CNT_TWO;
        tx_next   = txc_q + tx_add;
        rd_drains = (rxc_q <= CNT_TWO);
        rd_raw    = {(rxc_q >= CNT_TWO) ? data_q[HOST_W-1:BYTE_W] : {BYTE_W{1'b0}},
                     data_q[BYTE_W-1:0]};
    end

    // Next-state logic (T1..T5)
    always_comb begin
        state_d = state_q;
        if (op == OP_START) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (op == OP_WRITE && wr_ok)       state_d = ST_TXHOLD;
                    else if (op == OP_PUSH && push_ok) state_d = ST_RXHOLD;
                end
                ST_TXHOLD: begin
                    if (op == OP_POP && txc_q == CNT_ONE) state_d = ST_IDLE;
                end
                ST_RXHOLD: begin
                    if (op == OP_READ && rd_drains) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Storage, counts and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            txc_q    <= '0;
            rxc_q    <= '0;
            rd_q     <= '0;
            tx_rdy_q <= 1'b0;
            rx_rdy_q <= 1'b0;
            single_q <= 1'b0;
            udf_q    <= 1'b0;
            ovr_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (op)
                OP_START: begin
                    data_q   <= '0;
                    txc_q    <= '0;
                    rxc_q    <= '0;
                    rx_rdy_q <= 1'b0;
                    tx_rdy_q <= 1'b1;
                    single_q <= 1'b0;
                end
                OP_WRITE: begin
                    udf_q <= 1'b0;
                    if (wr_ok) begin
                        if (wr_byte_i) data_q <= {data_q[BUF_W-BYTE_W-1:0], wr_data_i[BYTE_W-1:0]};
                        else           data_q <= {data_q[BUF_W-HOST_W-1:0], wr_word};
                        txc_q <= tx_next;
                        if (tx_next > WR_LIMIT) tx_rdy_q <= 1'b0;
                    end
                end
                OP_READ: begin
                    ovr_q <= 1'b0;
                    if (rxc_q == '0) begin
                        rd_q  <= '0;
                        err_q <= 1'b1;
                    end else begin
                        rd_q <= rd_word;
                        if (rxc_q == CNT_ONE) single_q <= 1'b1;
                        if (rd_drains) begin
                            rxc_q    <= '0;
                            rx_rdy_q <= 1'b0;
                        end else begin
                            data_q <= data_q >> HOST_W;
                            rxc_q  <= rxc_q - CNT_TWO;
                        end
                    end
                end
                OP_POP: begin
                    if (txc_q == '0) begin
                        udf_q <= 1'b1;
                    end else begin
                        txc_q <= txc_q - CNT_ONE;
                        if (txc_q - CNT_ONE <= WR_LIMIT) tx_rdy_q <= 1'b1;
                    end
                end
                OP_PUSH: begin
                    if (push_ok) begin
                        for (int i = 0; i < DEPTH; i++) begin
                            if (rxc_q == CNT_W'(i)) data_q[i*BYTE_W +: BYTE_W] <= rx_byte_i;
                        end
                        rxc_q    <= rxc_q + CNT_ONE;
                        rx_rdy_q <= 1'b1;
                    end else begin
                        ovr_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_data_o = rd_q;
    assign tx_cnt_o  = txc_q;
    assign rx_cnt_o  = rxc_q;
    assign tx_rdy_o  = tx_rdy_q;
    assign rx_rdy_o  = rx_rdy_q;
    assign single_o  = single_q;
    assign tx_udf_o  = udf_q;
    assign rx_ovr_o  = ovr_q;
    assign acc_err_o = err_q;

endmodule

// File: rtl/bytepack_buf_chk.sv
module bytepack_buf_chk #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic                        wr_en_i,
    input logic                        rd_en_i,
    input logic [2*BYTE_W-1:0]         rd_data_o,
    input logic [$clog2(DEPTH+1)-1:0]  tx_cnt_o,
    input logic [$clog2(DEPTH+1)-1:0]  rx_cnt_o,
    input logic                        tx_rdy_o,
    input logic                        rx_rdy_o,
    input logic                        single_o,
    input logic                        tx_udf_o,
    input logic                        rx_ovr_o,
    input logic                        acc_err_o
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - 2);

    // R3
    refuse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !start_i && tx_cnt_o > LIMIT) |=> $stable(tx_cnt_o));

    // R3
    refuse_rxheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !start_i && rx_cnt_o != '0) |=> (tx_cnt_o == '0));

    // R6
    udf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !start_i) |=> !tx_udf_o);

    // R7
    txrdy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt_o > LIMIT) |-> !tx_rdy_o);

    // R8
    rxrdy_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy_o == (rx_cnt_o != '0));

    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !start_i && !wr_en_i) |=> !rx_ovr_o);

    // R8
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((tx_cnt_o != '0) && (rx_cnt_o != '0)));

    // R10
    lone_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !start_i && !wr_en_i && rx_cnt_o == CNT_W'(1))
        |=> (single_o && rx_cnt_o == '0));

    // R11
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !start_i && !wr_en_i && rx_cnt_o == '0)
        |=> (acc_err_o && rd_data_o == '0 && rx_cnt_o == '0));

    // R12
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tx_cnt_o == '0 && rx_cnt_o == '0 && tx_rdy_o && !single_o));

endmodule

bind bytepack_buf bytepack_buf_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .tx_cnt_o  (tx_cnt_o),
    .rx_cnt_o  (rx_cnt_o),
    .tx_rdy_o  (tx_rdy_o),
    .rx_rdy_o  (rx_rdy_o),
    .single_o  (single_o),
    .tx_udf_o  (tx_udf_o),
    .rx_ovr_o  (rx_ovr_o),
    .acc_err_o (acc_err_o)
);

// File: tb/bytepack_buf_bench.sv
module bytepack_buf_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, swap_i = 0, wr_en_i = 0, wr_byte_i = 0;
    logic [15:0] wr_data_i = '0;
    logic        rd_en_i = 0, tx_pop_i = 0, rx_push_i = 0;
    logic [7:0]  rx_byte_i = '0;
    logic [15:0] rd_data_o;
    logic [7:0]  tx_byte_o;
    logic [2:0]  tx_cnt_o, rx_cnt_o;
    logic        tx_rdy_o, rx_rdy_o, single_o, tx_udf_o, rx_ovr_o, acc_err_o;

    always #10 clk = ~clk;

    bytepack_buf u_bytepack_buf (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .swap_i(swap_i),
        .wr_en_i(wr_en_i), .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .tx_pop_i(tx_pop_i), .tx_byte_o(tx_byte_o),
        .rx_push_i(rx_push_i), .rx_byte_i(rx_byte_i),
        .tx_cnt_o(tx_cnt_o), .rx_cnt_o(rx_cnt_o),
        .tx_rdy_o(tx_rdy_o), .rx_rdy_o(rx_rdy_o), .single_o(single_o),
        .tx_udf_o(tx_udf_o), .rx_ovr_o(rx_ovr_o), .acc_err_o(acc_err_o)
    );

    // Reference model
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    bit          m_txrdy = 0, m_udf = 0, m_ovr = 0, m_single = 0, m_acc = 0;
    logic [15:0] m_rd = '0;
    int          vectors = 0, errors = 0;
    bit          run_cmp = 0, done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_txrdy = 0; m_udf = 0; m_ovr = 0; m_single = 0; m_acc = 0; m_rd = '0;
        end else begin
            m_acc = 0;
            if (start_i) begin
                txq.delete(); rxq.delete();
                m_txrdy = 1; m_single = 0;
            end else if (wr_en_i) begin
                m_udf = 0;
                if (rxq.size() == 0 && txq.size() <= 2) begin
                    if (wr_byte_i) txq.push_back(wr_data_i[7:0]);
                    else if (swap_i) begin txq.push_back(wr_data_i[15:8]); txq.push_back(wr_data_i[7:0]); end
                    else begin txq.push_back(wr_data_i[7:0]); txq.push_back(wr_data_i[15:8]); end
                    if (txq.size() > 2) m_txrdy = 0;
                end
            end else if (rd_en_i) begin
                m_ovr = 0;
                if (rxq.size() == 0) begin
                    m_rd = '0; m_acc = 1;
                end else if (rxq.size() == 1) begin
                    logic [7:0] b;
                    b = rxq.pop_front();
                    m_rd = swap_i ? {b, 8'h00} : {8'h00, b};
                    m_single = 1;
                end else begin
                    logic [7:0] a, b;
                    a = rxq.pop_front();
                    b = rxq.pop_front();
                    m_rd = swap_i ? {a, b} : {b, a};
                end
            end else if (tx_pop_i) begin
                if (txq.size() == 0) m_udf = 1;
                else begin
                    void'(txq.pop_front());
                    if (txq.size() <= 2) m_txrdy = 1;
                end
            end else if (rx_push_i) begin
                if (txq.size() == 0 && rxq.size() < 4) rxq.push_back(rx_byte_i);
                else m_ovr = 1;
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (run_cmp) begin
            check("R3", "tx_cnt", 32'(tx_cnt_o), 32'(txq.size()));
            check("R8", "rx_cnt", 32'(rx_cnt_o), 32'(rxq.size()));
            check("R6", "tx_byte", 32'(tx_byte_o), (txq.size() != 0) ? 32'(txq[0]) : 32'd0);
            check("R9", "rd_data", 32'(rd_data_o), 32'(m_rd));
            check("R6", "tx_udf", 32'(tx_udf_o), 32'(m_udf));
            check("R8", "rx_ovr", 32'(rx_ovr_o), 32'(m_ovr));
            check("R7", "tx_rdy", 32'(tx_rdy_o), 32'(m_txrdy));
            check("R8", "rx_rdy", 32'(rx_rdy_o), 32'(rxq.size() != 0));
            check("R10", "single", 32'(single_o), 32'(m_single));
            check("R11", "acc_err", 32'(acc_err_o), 32'(m_acc));
        end
    end

    task automatic clear_req();
        start_i = 0; wr_en_i = 0; wr_byte_i = 0; rd_en_i = 0; tx_pop_i = 0; rx_push_i = 0;
    endtask
    task automatic idle();      @(negedge clk); clear_req(); endtask
    task automatic do_start();  @(negedge clk); clear_req(); start_i = 1; endtask
    task automatic wr16(logic [15:0] d); @(negedge clk); clear_req(); wr_en_i = 1; wr_data_i = d; endtask
    task automatic wr8(logic [7:0] d);   @(negedge clk); clear_req(); wr_en_i = 1; wr_byte_i = 1; wr_data_i = {8'h00, d}; endtask
    task automatic rd();        @(negedge clk); clear_req(); rd_en_i = 1; endtask
    task automatic pop();       @(negedge clk); clear_req(); tx_pop_i = 1; endtask
    task automatic push(logic [7:0] b);  @(negedge clk); clear_req(); rx_push_i = 1; rx_byte_i = b; endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset tx_cnt", 32'(tx_cnt_o), 0);
        check("R1", "reset rx_cnt", 32'(rx_cnt_o), 0);
        check("R1", "reset rd_data", 32'(rd_data_o), 0);
        check("R1", "reset tx_byte", 32'(tx_byte_o), 0);
        check("R1", "reset flags", 32'({tx_rdy_o, rx_rdy_o, single_o, tx_udf_o, rx_ovr_o, acc_err_o}), 0);
        rst_n = 1;
        run_cmp = 1;

        do_start(); idle();
        check("R12", "tx_rdy after start", 32'(tx_rdy_o), 1);

        swap_i = 0; wr16(16'hA1B2); idle();
        check("R5", "low byte first", 32'(tx_byte_o), 32'h B2);
        check("R3", "count after write", 32'(tx_cnt_o), 2);
        swap_i = 1; wr16(16'hC3D4); idle();
        check("R7", "tx_rdy at 4", 32'(tx_rdy_o), 0);

        // R2: write refused, pop in same cycle ignored
        @(negedge clk); clear_req(); wr_en_i = 1; wr_data_i = 16'hEEEE; tx_pop_i = 1;
        idle();
        check("R2", "pop under write", 32'(tx_cnt_o), 4);
        check("R2", "oldest kept", 32'(tx_byte_o), 32'hB2);

        pop(); idle();
        check("R6", "second byte", 32'(tx_byte_o), 32'hA1);
        pop(); idle();
        check("R5", "swapped high first", 32'(tx_byte_o), 32'hC3);
        check("R7", "tx_rdy at 2", 32'(tx_rdy_o), 1);
        pop(); pop(); pop(); idle();
        check("R6", "underflow", 32'(tx_udf_o), 1);

        wr8(8'h5C); idle();
        check("R4", "byte write count", 32'(tx_cnt_o), 1);
        check("R6", "underflow cleared", 32'(tx_udf_o), 0);
        push(8'h99); idle();
        check("R8", "push while tx held", 32'(rx_ovr_o), 1);
        wr16(16'h1234); wr8(8'h77); idle();
        check("R4", "byte write refused", 32'(tx_cnt_o), 3);
        pop(); pop(); pop();

        rd(); idle();
        check("R11", "empty read pulse", 32'(acc_err_o), 1);
        check("R8", "overrun cleared by read", 32'(rx_ovr_o), 0);
        idle();
        check("R11", "pulse one cycle", 32'(acc_err_o), 0);

        push(8'h11); push(8'h22); push(8'h33); push(8'h44); push(8'h55); idle();
        check("R8", "full push overrun", 32'(rx_ovr_o), 1);
        wr16(16'hBEEF); idle();
        check("R3", "write while rx held", 32'(tx_cnt_o), 0);
        swap_i = 0; rd(); idle();
        check("R9", "read unswapped", 32'(rd_data_o), 32'h2211);
        swap_i = 1; rd(); idle();
        check("R9", "read swapped", 32'(rd_data_o), 32'h3344);
        swap_i = 0; push(8'h77); rd(); idle();
        check("R10", "lone byte", 32'(rd_data_o), 32'h0077);
        check("R10", "single flag", 32'(single_o), 1);
        push(8'h88); do_start(); idle();
        check("R12", "start clears", 32'({rx_cnt_o, single_o, rx_rdy_o}), 0);

        // Random overlapping requests, checked by the model each clock
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            start_i   = ($urandom_range(0, 49) == 0);
            wr_en_i   = ($urandom_range(0, 3) == 0);
            wr_byte_i = ($urandom_range(0, 3) == 0);
            wr_data_i = 16'($urandom);
            rd_en_i   = ($urandom_range(0, 3) == 0);
            tx_pop_i  = ($urandom_range(0, 2) == 0);
            rx_push_i = ($urandom_range(0, 2) == 0);
            rx_byte_i = 8'($urandom);
            swap_i    = 1'($urandom);
        end
        idle(); idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule